// File: doc/BRIEF.md
# ADC Channel Sequencer

This block decides which analog input a single converter samples on each start event. The converter sees its inputs through two 8-way analog multiplexers, A and B. The sequencer drives the enable and select lines of both multiplexers and runs a start/busy/done handshake with the converter. It returns every converted word tagged with the logical channel it belongs to.

Software loads a channel range, given as first and last channel. It also picks single-ended or differential numbering, and one of two sampling modes. In sample mode each trigger pulse converts one channel, and the channel steps through the range in rotation. In scan mode a single trigger converts the whole range back to back, in ascending order, and flags the end of the scan. The total conversion rate is the trigger rate multiplied by the number of channels converted per trigger. The system must keep this total within the converter's limit of 100k conversions per second. Triggers that arrive while work is still in progress are dropped and recorded in a sticky overrun flag.

Top module: `adc_chan_seq`

## Requirements
- R1: After reset every pulse output is low and `ovr_flag` is 0. The mux outputs select input 0: `mux_a_en`=1, `mux_a_sel`=0, `mux_b_en`=0, `mux_b_sel`=0. The configuration is range 0..0, single-ended, sample mode, so the first trigger converts channel 0.
- R2: In single-ended mode there are 16 channels. A channel c below 8 sets `mux_a_en`=1, `mux_a_sel`=c and `mux_b_en`=0. A channel c of 8 or more sets `mux_b_en`=1, `mux_b_sel`=c-8 and `mux_a_en`=0. The lines settle before `adc_start` is raised.
- R3: In differential mode there are 8 channels, and only the low three bits of `cfg_first` and `cfg_last` count. Channel n sets both enables to 1 and both selects to n, so input n is paired with input n+8. Bit 3 of `res_chan` is always 0.
- R4: A one-cycle `cfg_load` while the block is idle latches the range, the numbering mode and the sampling mode, and it moves the rotation pointer to the first channel. A last channel below the first is treated as a single channel equal to the first. A `cfg_load` while a conversion or scan is in progress is ignored. When `cfg_load` and `trig` arrive in the same idle cycle, the load wins and the trigger is discarded.
- R5: In sample mode each accepted trigger converts exactly one channel. The next trigger converts the following channel, and after the last channel the rotation wraps to the first. A single-channel range converts the same channel every time.
- R6: In scan mode one trigger converts every channel from first to last in ascending order without further triggers. Each start waits for the previous done. Every scan begins again at the first channel.
- R7: `adc_start` is a one-cycle pulse. It is never raised while `adc_busy` is high, and at most one conversion is outstanding at any time.
- R8: One cycle after `adc_done`, `res_valid` pulses for one cycle. It carries `res_data` equal to the `adc_data` sampled with done, and `res_chan` equal to the logical channel that was converted.
- R9: `scan_done` pulses only in scan mode, in the same cycle as the result of the last channel of the range.
- R10: A trigger that arrives while the block is not idle starts no conversion and sets `ovr_flag`. The flag stays set until `ovr_clr` is pulsed. If a set and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Pulse that latches the configuration inputs |
| cfg_first | input | 4 | First channel of the range |
| cfg_last | input | 4 | Last channel of the range |
| cfg_diff | input | 1 | 1 = differential numbering, 0 = single-ended |
| cfg_scan | input | 1 | 1 = scan mode, 0 = sample mode |
| trig | input | 1 | Trigger or clock pulse, one cycle |
| ovr_clr | input | 1 | Clears the overrun flag |
| adc_start | output | 1 | Conversion start pulse |
| adc_busy | input | 1 | Converter busy |
| adc_done | input | 1 | Conversion complete, data valid |
| adc_data | input | DATA_W | Converted word |
| mux_a_en | output | 1 | Enable for multiplexer A (inputs 0..7) |
| mux_a_sel | output | 3 | Select for multiplexer A |
| mux_b_en | output | 1 | Enable for multiplexer B (inputs 8..15) |
| mux_b_sel | output | 3 | Select for multiplexer B |
| res_valid | output | 1 | Result strobe |
| res_data | output | DATA_W | Result word |
| res_chan | output | 4 | Logical channel tag |
| scan_done | output | 1 | End-of-scan pulse |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
The bench goes after these corner cases:

- **Mux boundary.** A sample-mode range from 6 to 9 crosses from multiplexer A to B and then wraps. A wrong boundary decode would enable the wrong multiplexer, and a wrong wrap would run past the last channel.
- **Reversed and differential ranges.** A range with last below first must keep converting the first channel. A differential range loaded with bit 3 set must fold onto channels 0..7, with both multiplexers enabled. A design that kept bit 3 would tag results 8 and above.
- **Scan restart and ignored load.** Repeated scans must restart at the first channel. A `cfg_load` during a scan must leave that scan and the next one unchanged. A design that accepted the load would truncate the scan or change the channels.
- **Overrun and busy hold.** Triggers dropped mid-scan must add no conversions and must set the flag, and a set must beat a simultaneous clear. An external busy held high must delay the start until it falls. A design that queued triggers, or ignored busy, would show extra or early starts.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_CONV  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/adc_seq_cfg.sv
// Configuration holding register with range normalisation.
module adc_seq_cfg #(
  parameter int SEL_W = 3,
  localparam int CH_W = SEL_W + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [CH_W-1:0] first_in,
  input  logic [CH_W-1:0] last_in,
  input  logic            diff_in,
  input  logic            scan_in,
  output logic [CH_W-1:0] first_nxt,
  output logic [CH_W-1:0] first_q,
  output logic [CH_W-1:0] last_q,
  output logic            diff_q,
  output logic            scan_q
);

  logic [CH_W-1:0] last_eff;
  logic [CH_W-1:0] last_nxt;

  // Differential numbering only uses the low select bits.
  always_comb begin
    if (diff_in) begin
      first_nxt = {1'b0, first_in[SEL_W-1:0]};
      last_eff  = {1'b0, last_in[SEL_W-1:0]};
    end else begin
      first_nxt = first_in;
      last_eff  = last_in;
    end
    last_nxt = (last_eff < first_nxt) ? first_nxt : last_eff;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= '0;
      last_q  <= '0;
      diff_q  <= 1'b0;
      scan_q  <= 1'b0;
    end else if (we) begin
      first_q <= first_nxt;
      last_q  <= last_nxt;
      diff_q  <= diff_in;
      scan_q  <= scan_in;
    end
  end

  AST_RANGE_ORDERED: assert property (@(posedge clk) disable iff (rst)
    last_q >= first_q);  // R4
  AST_DIFF_FOLDED: assert property (@(posedge clk) disable iff (rst)
    diff_q |-> (!first_q[CH_W-1] && !last_q[CH_W-1]));  // R3

endmodule

// File: rtl/adc_seq_mux.sv
// Registered logical-channel to multiplexer line decode.
module adc_seq_mux #(
  parameter int SEL_W = 3,
  localparam int CH_W = SEL_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [CH_W-1:0]  chan,
  input  logic             diff,
  output logic             a_en,
  output logic [SEL_W-1:0] a_sel,
  output logic             b_en,
  output logic [SEL_W-1:0] b_sel
);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_en  <= 1'b1;
      a_sel <= '0;
      b_en  <= 1'b0;
      b_sel <= '0;
    end else if (ld) begin
      if (diff) begin
        a_en  <= 1'b1;
        b_en  <= 1'b1;
        a_sel <= chan[SEL_W-1:0];
        b_sel <= chan[SEL_W-1:0];
      end else if (chan[CH_W-1]) begin
        a_en  <= 1'b0;
        a_sel <= '0;
        b_en  <= 1'b1;
        b_sel <= chan[SEL_W-1:0];
      end else begin
        a_en  <= 1'b1;
        a_sel <= chan[SEL_W-1:0];
        b_en  <= 1'b0;
        b_sel <= '0;
      end
    end
  end

  AST_SE_ONE_MUX: assert property (@(posedge clk) disable iff (rst)
    (ld && !diff) |=> (a_en != b_en));  // R2
  AST_DIFF_PAIR: assert property (@(posedge clk) disable iff (rst)
    (ld && diff) |=> (a_en && b_en && (a_sel == b_sel)));  // R3

endmodule

// File: rtl/adc_seq_ctrl.sv
// Sequencing FSM: trigger acceptance, converter handshake, result tagging.
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SEL_W  = 3,
  parameter int DATA_W = 12,
  localparam int CH_W  = SEL_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [CH_W-1:0]   first_nxt,
  input  logic [CH_W-1:0]   first_q,
  input  logic [CH_W-1:0]   last_q,
  input  logic              scan_q,
  input  logic              trig,
  input  logic              ovr_clr,
  input  logic              adc_busy,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  output logic              cfg_we,
  output logic              mux_ld,
  output logic [CH_W-1:0]   mux_chan,
  output logic              adc_start,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic [CH_W-1:0]   res_chan,
  output logic              scan_done,
  output logic              ovr_flag
);

  seq_state_e      state;
  logic [CH_W-1:0] ptr;
  logic [CH_W-1:0] cur;
  logic            idle;
  logic            accept;
  logic            more;

  assign idle     = (state == ST_IDLE);
  assign cfg_we   = cfg_load && idle;
  assign accept   = trig && idle && !cfg_load;
  assign more     = scan_q && (cur != last_q);
  assign mux_ld   = accept || ((state == ST_CONV) && adc_done && more);
  assign mux_chan = idle ? ptr : cur + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ptr       <= '0;
      cur       <= '0;
      adc_start <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_chan  <= '0;
      scan_done <= 1'b0;
      ovr_flag  <= 1'b0;
    end else begin
      adc_start <= 1'b0;
      res_valid <= 1'b0;
      scan_done <= 1'b0;

      if (trig && !idle) ovr_flag <= 1'b1;
      else if (ovr_clr)  ovr_flag <= 1'b0;

      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            cur   <= ptr;
            state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (!adc_busy) begin
            adc_start <= 1'b1;
            state     <= ST_CONV;
          end
        end
        ST_CONV: begin
          if (adc_done) begin
            res_valid <= 1'b1;
            res_data  <= adc_data;
            res_chan  <= cur;
            if (more) begin
              cur   <= cur + 1'b1;
              state <= ST_SETUP;
            end else begin
              state <= ST_IDLE;
              if (scan_q) begin
                scan_done <= 1'b1;
                ptr       <= first_q;
              end else begin
                ptr <= (cur == last_q) ? first_q : cur + 1'b1;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase

      if (cfg_we) ptr <= first_nxt;
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);  // R7
  AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> !$past(adc_busy));  // R7
  AST_RESULT_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(adc_done));  // R8
  AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
    (trig && !idle) |=> ovr_flag);  // R10
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovr_flag && !ovr_clr) |=> ovr_flag);  // R10

endmodule

// File: rtl/adc_chan_seq.sv
// Top level: channel sequencer for a converter behind two analog muxes.
module adc_chan_seq #(
  parameter int DATA_W    = 12,
  parameter int MUX_DEPTH = 8,
  localparam int SEL_W    = $clog2(MUX_DEPTH),
  localparam int CH_W     = SEL_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [CH_W-1:0]   cfg_first,
  input  logic [CH_W-1:0]   cfg_last,
  input  logic              cfg_diff,
  input  logic              cfg_scan,
  input  logic              trig,
  input  logic              ovr_clr,
  output logic              adc_start,
  input  logic              adc_busy,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  output logic              mux_a_en,
  output logic [SEL_W-1:0]  mux_a_sel,
  output logic              mux_b_en,
  output logic [SEL_W-1:0]  mux_b_sel,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic [CH_W-1:0]   res_chan,
  output logic              scan_done,
  output logic              ovr_flag
);

  logic            cfg_we;
  logic [CH_W-1:0] first_nxt;
  logic [CH_W-1:0] first_q;
  logic [CH_W-1:0] last_q;
  logic            diff_q;
  logic            scan_q;
  logic            mux_ld;
  logic [CH_W-1:0] mux_chan;

  adc_seq_cfg #(.SEL_W(SEL_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .first_in (cfg_first),
    .last_in  (cfg_last),
    .diff_in  (cfg_diff),
    .scan_in  (cfg_scan),
    .first_nxt(first_nxt),
    .first_q  (first_q),
    .last_q   (last_q),
    .diff_q   (diff_q),
    .scan_q   (scan_q)
  );

  adc_seq_ctrl #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cfg_load (cfg_load),
    .first_nxt(first_nxt),
    .first_q  (first_q),
    .last_q   (last_q),
    .scan_q   (scan_q),
    .trig     (trig),
    .ovr_clr  (ovr_clr),
    .adc_busy (adc_busy),
    .adc_done (adc_done),
    .adc_data (adc_data),
    .cfg_we   (cfg_we),
    .mux_ld   (mux_ld),
    .mux_chan (mux_chan),
    .adc_start(adc_start),
    .res_valid(res_valid),
    .res_data (res_data),
    .res_chan (res_chan),
    .scan_done(scan_done),
    .ovr_flag (ovr_flag)
  );

  adc_seq_mux #(.SEL_W(SEL_W)) u_mux (
    .clk  (clk),
    .rst  (rst),
    .ld   (mux_ld),
    .chan (mux_chan),
    .diff (diff_q),
    .a_en (mux_a_en),
    .a_sel(mux_a_sel),
    .b_en (mux_b_en),
    .b_sel(mux_b_sel)
  );

  AST_TAG_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ((res_chan >= first_q) && (res_chan <= last_q)));  // R5
  AST_DIFF_TAG_TOP: assert property (@(posedge clk) disable iff (rst)
    (res_valid && diff_q) |-> !res_chan[CH_W-1]);  // R3
  AST_SCAN_DONE_LAST: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> (res_valid && scan_q && (res_chan == last_q)));  // R9

endmodule

// File: tb/adc_chan_seq_bench.sv
module adc_chan_seq_bench;

  localparam int DATA_W = 12;
  localparam int LAT    = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_load = 1'b0;
  logic [3:0]        cfg_first = '0;
  logic [3:0]        cfg_last = '0;
  logic              cfg_diff = 1'b0;
  logic              cfg_scan = 1'b0;
  logic              trig = 1'b0;
  logic              ovr_clr = 1'b0;
  logic              adc_start;
  logic              adc_busy;
  logic              adc_done = 1'b0;
  logic [DATA_W-1:0] adc_data = '0;
  logic              mux_a_en, mux_b_en;
  logic [2:0]        mux_a_sel, mux_b_sel;
  logic              res_valid;
  logic [DATA_W-1:0] res_data;
  logic [3:0]        res_chan;
  logic              scan_done;
  logic              ovr_flag;

  logic model_busy = 1'b0;
  logic busy_hold  = 1'b0;
  assign adc_busy = model_busy | busy_hold;

  always #5 clk = ~clk;

  adc_chan_seq u_adc_chan_seq (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_first(cfg_first),
    .cfg_last(cfg_last), .cfg_diff(cfg_diff), .cfg_scan(cfg_scan),
    .trig(trig), .ovr_clr(ovr_clr), .adc_start(adc_start),
    .adc_busy(adc_busy), .adc_done(adc_done), .adc_data(adc_data),
    .mux_a_en(mux_a_en), .mux_a_sel(mux_a_sel), .mux_b_en(mux_b_en),
    .mux_b_sel(mux_b_sel), .res_valid(res_valid), .res_data(res_data),
    .res_chan(res_chan), .scan_done(scan_done), .ovr_flag(ovr_flag)
  );

  int checks = 0;
  int errors = 0;
  int nstarts = 0;
  int conv_cnt = 0;
  int m_first = 0, m_last = 0, m_ptr = 0;
  bit m_diff = 0, m_scan = 0;
  int exp_q[$];
  bit exp_sd_q[$];
  logic [DATA_W-1:0] data_q[$];
  bit done_run = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int decode_mux();
    if (mux_a_en && mux_b_en) return (mux_a_sel == mux_b_sel) ? int'(mux_a_sel) : -1;
    if (mux_a_en && !mux_b_en) return int'(mux_a_sel);
    if (mux_b_en && !mux_a_en) return 8 + int'(mux_b_sel);
    return -1;
  endfunction

  // Per-clock comparison against the reference queues, plus the converter model.
  always @(negedge clk) begin
    if (!rst) begin
      if (adc_done) adc_done = 1'b0;
      if (res_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8 unexpected result", int'(res_chan), -1);
        end else begin
          int ec;
          bit esd;
          logic [DATA_W-1:0] ed;
          ec  = exp_q.pop_front();
          esd = exp_sd_q.pop_front();
          ed  = (data_q.size() > 0) ? data_q.pop_front() : '1;
          chk(int'(res_chan) == ec, "R5 R6 channel tag", int'(res_chan), ec);
          chk(res_data == ed, "R8 result data", int'(res_data), int'(ed));
          chk(scan_done == esd, "R9 scan_done", int'(scan_done), int'(esd));
          if (m_diff) chk(!res_chan[3], "R3 tag top bit", int'(res_chan), ec);
        end
      end else if (scan_done) begin
        chk(0, "R9 scan_done without result", 1, 0);
      end
      if (adc_start) begin
        int d;
        nstarts++;
        d = decode_mux();
        chk(!adc_busy, "R7 start while busy", int'(adc_busy), 0);
        chk(exp_q.size() > 0 && d == exp_q[0], "R2 R3 mux lines", d,
            (exp_q.size() > 0) ? exp_q[0] : -1);
        if (m_diff) chk(mux_a_en && mux_b_en, "R3 both enabled", d, d);
        model_busy = 1'b1;
        conv_cnt   = LAT;
        adc_data   = {4'(d), 8'(nstarts)};
      end else if (model_busy) begin
        conv_cnt--;
        if (conv_cnt == 0) begin
          adc_done   = 1'b1;
          model_busy = 1'b0;
          data_q.push_back(adc_data);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load_pins(input int f, input int l, input bit d, input bit s);
    cfg_first = 4'(f); cfg_last = 4'(l); cfg_diff = d; cfg_scan = s;
    cfg_load = 1'b1;
    tick(1);
    cfg_load = 1'b0;
  endtask

  task automatic apply_cfg(input int f, input int l, input bit d, input bit s);
    load_pins(f, l, d, s);
    m_diff  = d;
    m_scan  = s;
    m_first = d ? (f & 7) : f;
    m_last  = d ? (l & 7) : l;
    if (m_last < m_first) m_last = m_first;
    m_ptr = m_first;
    tick(1);
  endtask

  task automatic push_expected();
    if (m_scan) begin
      for (int c = m_first; c <= m_last; c++) begin
        exp_q.push_back(c);
        exp_sd_q.push_back(c == m_last);
      end
      m_ptr = m_first;
    end else begin
      exp_q.push_back(m_ptr);
      exp_sd_q.push_back(1'b0);
      m_ptr = (m_ptr == m_last) ? m_first : m_ptr + 1;
    end
  endtask

  task automatic pulse_trig();
    trig = 1'b1;
    tick(1);
    trig = 1'b0;
  endtask

  task automatic wait_idle();
    int lim = 400;
    while (exp_q.size() != 0 && lim > 0) begin
      tick(1);
      lim--;
    end
    if (lim == 0) chk(0, "R6 results missing", exp_q.size(), 0);
    tick(3);
  endtask

  task automatic fire();
    push_expected();
    pulse_trig();
    wait_idle();
  endtask

  initial begin
    int s0;
    tick(4);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!adc_start && !res_valid && !scan_done, "R1 pulses low", int'(adc_start), 0);
    chk(!ovr_flag, "R1 ovr_flag", int'(ovr_flag), 0);
    chk(mux_a_en && !mux_b_en && mux_a_sel == 0 && mux_b_sel == 0,
        "R1 mux lines", decode_mux(), 0);
    tick(1);
    fire();  // R1: default configuration converts channel 0

    // R2 R5: single-ended range crossing mux boundary, with wrap
    apply_cfg(6, 9, 0, 0);
    for (int i = 0; i < 6; i++) fire();

    // R5: single channel repeats
    apply_cfg(13, 13, 0, 0);
    for (int i = 0; i < 3; i++) fire();

    // R6 R9: scan, twice, restarting at first
    apply_cfg(2, 5, 0, 1);
    fire();
    fire();

    // R3: differential scan with bit 3 set in the range inputs
    apply_cfg(9, 14, 1, 1);
    fire();

    // R3 R5: differential sample with wrap
    apply_cfg(5, 7, 1, 0);
    for (int i = 0; i < 4; i++) fire();

    // R4: reversed range acts as single channel at first
    apply_cfg(10, 4, 0, 0);
    for (int i = 0; i < 2; i++) fire();

    // R4: reload resets rotation pointer
    apply_cfg(0, 3, 0, 0);
    fire(); fire();
    apply_cfg(0, 3, 0, 0);
    fire();

    // R4: load during a scan is ignored
    apply_cfg(4, 7, 0, 1);
    push_expected();
    pulse_trig();
    tick(3);
    load_pins(0, 1, 1, 0);
    wait_idle();
    fire();

    // R4: load and trigger in the same idle cycle, load wins
    apply_cfg(1, 2, 0, 0);
    s0 = nstarts;
    cfg_first = 4'd3; cfg_last = 4'd3; cfg_diff = 0; cfg_scan = 0;
    cfg_load = 1'b1; trig = 1'b1;
    tick(1);
    cfg_load = 1'b0; trig = 1'b0;
    m_first = 3; m_last = 3; m_ptr = 3;
    tick(10);
    chk(nstarts == s0, "R4 trigger with load discarded", nstarts - s0, 0);
    fire();

    // R10: overrun dropped and flagged, then cleared
    apply_cfg(0, 3, 0, 1);
    s0 = nstarts;
    push_expected();
    pulse_trig();
    tick(4);
    pulse_trig();
    wait_idle();
    chk(nstarts - s0 == 4, "R10 dropped trigger", nstarts - s0, 4);
    chk(ovr_flag, "R10 flag set", int'(ovr_flag), 1);
    ovr_clr = 1'b1; tick(1); ovr_clr = 1'b0;
    @(negedge clk);
    chk(!ovr_flag, "R10 flag cleared", int'(ovr_flag), 0);
    tick(1);
    push_expected();
    pulse_trig();
    tick(3);
    trig = 1'b1; ovr_clr = 1'b1;
    tick(1);
    trig = 1'b0; ovr_clr = 1'b0;
    wait_idle();
    chk(ovr_flag, "R10 set beats clear", int'(ovr_flag), 1);
    ovr_clr = 1'b1; tick(1); ovr_clr = 1'b0;

    // R7: external busy holds off the start
    apply_cfg(11, 11, 0, 0);
    busy_hold = 1'b1;
    s0 = nstarts;
    push_expected();
    pulse_trig();
    tick(10);
    chk(nstarts == s0, "R7 start held by busy", nstarts - s0, 0);
    busy_hold = 1'b0;
    wait_idle();
    chk(nstarts == s0 + 1, "R7 start after busy", nstarts - s0, 1);

    done_run = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_run) begin
      chk(0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule